// File: doc/BRIEF.md
# Write-Busy Status Read Multiplexer

This block sits in the read data path of a byte-wide nonvolatile memory. It decides what a read returns while an internal programming cycle is running. Software can find out when the write has finished in two ways, and both work at the same time. While the memory is busy, a read at the address that was last written returns bit 7 inverted from the byte that was written. On every busy read, whatever the address, bit 6 flips. Once the busy flag drops, each read returns the true array byte on all eight bits, and bit 6 stops changing.

The block is synchronous. A read access is one rising edge of the read-enable level `rd_en`, sampled on `clk`. That level can come from either output enable or chip enable. On the clock edge that sees the rising edge, the block composes the output byte from `busy`, the address match, the latched last-written address and data, the array data and the toggle state. It registers that byte on `rd_data`, where the byte holds until the next access. The toggle state is not cleared when a write cycle ends. Software therefore sees an undefined starting level, and only the change between two reads tells it anything. Tri-state pin control and analog timing are not part of this block.

Top module: `wbsr_top`

## Requirements
- R1: After synchronous reset, `rd_data` is 0x00 and the toggle state is cleared. The first busy read after reset therefore returns bit 6 = 1.
- R2: An access with `busy` low returns `array_data`, as sampled at that access, on all eight bits. This includes the first read after `busy` falls.
- R3: An access with `busy` high and `rd_addr == last_addr` returns bit 7 = NOT `last_data[7]` and bits 5..0 = `last_data[5:0]`.
- R4: An access with `busy` high and `rd_addr != last_addr` returns bit 7 and bits 5..0 from `array_data`.
- R5: Every access with `busy` high inverts the toggle state, whatever `rd_addr` is. Output bit 6 carries the new toggle value.
- R6: One rising edge of `rd_en` is exactly one access. Holding `rd_en` high for more cycles neither flips the toggle again nor reloads `rd_data`.
- R7: Accesses with `busy` low leave the toggle state unchanged. The state carries over from one write cycle to the next, so the first busy read of a new cycle continues the alternation.
- R8: `rd_data` changes only on the clock edge where a rising edge of `rd_en` is seen. Between accesses it holds, even when the other inputs change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busy | input | 1 | Internal programming cycle in progress |
| rd_en | input | 1 | Read-enable level; each rising edge is one access |
| rd_addr | input | ADDR_W | Address of the current read |
| last_addr | input | ADDR_W | Latched address of the last byte written |
| last_data | input | 8 | Latched data of the last byte written |
| array_data | input | 8 | Byte read from the storage array at `rd_addr` |
| rd_data | output | 8 | Registered read result |

## Verification
The hardest behaviour to reach from the ports is the toggle state's memory. It carries across idle reads and from one busy window to the next, and a held read-enable must count only once. The stimulus interleaves busy reads with idle reads and with reads at other addresses. It then opens a second busy window and checks that bit 6 continues from where it stopped. One access holds `rd_en` high for several cycles and changes the array data in the meantime. That shows neither a second flip nor a reload.

// File: rtl/wbsr_pkg.sv
package wbsr_pkg;

    localparam int unsigned DATA_W   = 8;
    localparam int unsigned POLL_BIT = DATA_W - 1;
    localparam int unsigned TGL_BIT  = DATA_W - 2;

    typedef logic [DATA_W-1:0] byte_t;

    typedef enum logic [1:0] {
        SRC_ARRAY   = 2'd0,
        SRC_POLL    = 2'd1,
        SRC_BUSYOTH = 2'd2
    } rd_src_e;

    typedef struct packed {
        rd_src_e src;
        logic    tgl;
        byte_t   last;
        byte_t   arr;
    } rd_ctx_t;

    function automatic rd_src_e pick_src(input logic busy, input logic hit);
        if (!busy)      return SRC_ARRAY;
        else if (hit)   return SRC_POLL;
        else            return SRC_BUSYOTH;
    endfunction

    function automatic byte_t compose(input rd_ctx_t c);
        byte_t r;
        case (c.src)
            SRC_POLL: begin
                r            = c.last;
                r[POLL_BIT]  = ~c.last[POLL_BIT];
                r[TGL_BIT]   = c.tgl;
            end
            SRC_BUSYOTH: begin
                r            = c.arr;
                r[TGL_BIT]   = c.tgl;
            end
            default: r = c.arr;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/wbsr_strobe_detect.sv
module wbsr_strobe_detect (
    input  logic clk,
    input  logic rst,
    input  logic rd_en,
    output logic strobe
);
    logic rd_en_q;

    always_ff @(posedge clk) begin
        if (rst) rd_en_q <= 1'b1;
        else     rd_en_q <= rd_en;
    end

    assign strobe = rd_en & ~rd_en_q;

    // R6: a held level never yields two accesses in a row
    p_single_r6: assert property (@(posedge clk) disable iff (rst)
        strobe |=> !strobe);

endmodule

// File: rtl/wbsr_toggle.sv
module wbsr_toggle (
    input  logic clk,
    input  logic rst,
    input  logic busy,
    input  logic strobe,
    output logic tgl_q,
    output logic tgl_nxt
);
    logic flip;

    assign flip    = busy & strobe;
    assign tgl_nxt = tgl_q ^ flip;

    always_ff @(posedge clk) begin
        if (rst) tgl_q <= 1'b0;
        else     tgl_q <= tgl_nxt;
    end

    // R5: each busy access inverts the state
    p_flip_r5: assert property (@(posedge clk) disable iff (rst)
        (busy && strobe) |=> (tgl_q != $past(tgl_q)));

    // R7: idle accesses and non-access cycles keep the state
    p_keep_r7: assert property (@(posedge clk) disable iff (rst)
        !(busy && strobe) |=> $stable(tgl_q));

endmodule

// File: rtl/wbsr_addr_match.sv
module wbsr_addr_match #(
    parameter int unsigned ADDR_W = 15
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [ADDR_W-1:0] last_addr,
    output logic              hit
);
    logic [ADDR_W-1:0] diff;

    for (genvar i = 0; i < ADDR_W; i++) begin : g_cmp
        assign diff[i] = rd_addr[i] ^ last_addr[i];
    end

    assign hit = ~|diff;

endmodule

// File: rtl/wbsr_top.sv
module wbsr_top
    import wbsr_pkg::*;
#(
    parameter int unsigned ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              busy,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [ADDR_W-1:0] last_addr,
    input  logic [DATA_W-1:0] last_data,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] rd_data
);
    logic    strobe;
    logic    hit;
    logic    tgl_q;
    logic    tgl_nxt;
    rd_ctx_t ctx;
    byte_t   composed;
    byte_t   rd_q;

    wbsr_strobe_detect u_edge (
        .clk    (clk),
        .rst    (rst),
        .rd_en  (rd_en),
        .strobe (strobe)
    );

    wbsr_toggle u_tgl (
        .clk     (clk),
        .rst     (rst),
        .busy    (busy),
        .strobe  (strobe),
        .tgl_q   (tgl_q),
        .tgl_nxt (tgl_nxt)
    );

    wbsr_addr_match #(.ADDR_W(ADDR_W)) u_match (
        .rd_addr   (rd_addr),
        .last_addr (last_addr),
        .hit       (hit)
    );

    always_comb begin
        ctx.src  = pick_src(busy, hit);
        ctx.tgl  = tgl_nxt;
        ctx.last = last_data;
        ctx.arr  = array_data;
        composed = compose(ctx);
    end

    always_ff @(posedge clk) begin
        if (rst)         rd_q <= '0;
        else if (strobe) rd_q <= composed;
    end

    assign rd_data = rd_q;

    // R8: output only moves on an access
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> $stable(rd_data));

    // R2: idle access returns the array byte unchanged
    p_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (strobe && !busy) |=> (rd_data == $past(array_data)));

    // R3: polling bit is inverted for the last-written address
    p_poll_r3: assert property (@(posedge clk) disable iff (rst)
        (strobe && busy && hit) |=>
            (rd_data[POLL_BIT] != $past(last_data[POLL_BIT])));

    // R4: other busy reads pass array bit 7
    p_other_r4: assert property (@(posedge clk) disable iff (rst)
        (strobe && busy && !hit) |=>
            (rd_data[POLL_BIT] == $past(array_data[POLL_BIT])));

    // R5: bit 6 of a busy read equals the toggle state after the flip
    p_tglout_r5: assert property (@(posedge clk) disable iff (rst)
        (strobe && busy) |=> (rd_data[TGL_BIT] == tgl_q));

endmodule

// File: tb/wbsr_top_test.sv
module wbsr_top_test;
    localparam int AW = 15;

    logic          clk = 1'b0;
    logic          rst;
    logic          busy;
    logic          rd_en;
    logic [AW-1:0] rd_addr;
    logic [AW-1:0] last_addr;
    logic [7:0]    last_data;
    logic [7:0]    array_data;
    logic [7:0]    rd_data;

    int vectors  = 0;
    int miscomp  = 0;
    logic btgl   = 1'b0;
    logic [7:0] last_exp = 8'h00;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    wbsr_top #(.ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .busy(busy), .rd_en(rd_en),
        .rd_addr(rd_addr), .last_addr(last_addr), .last_data(last_data),
        .array_data(array_data), .rd_data(rd_data)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscomp++;
            $display("FAIL %s: rd_data=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // monitor: compares queued expectations away from the edge
    always @(posedge clk) begin
        #2;
        while (exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(t, rd_data, e);
        end
    end

    task automatic set_ctx(input logic b, input logic [AW-1:0] la,
                           input logic [7:0] ld, input logic [7:0] ad);
        @(negedge clk);
        busy = b; last_addr = la; last_data = ld; array_data = ad;
    endtask

    // driver: one access, rd_en held for 'hold' cycles
    task automatic rd(input logic [AW-1:0] a, input int hold, input string tag);
        logic [7:0] e;
        @(negedge clk);
        rd_addr = a;
        if (!busy) e = array_data;
        else begin
            btgl = ~btgl;
            if (a == last_addr) e = {~last_data[7], btgl, last_data[5:0]};
            else                e = {array_data[7], btgl, array_data[5:0]};
        end
        rd_en = 1'b1;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            if (i == 0 && hold > 1) array_data = ~array_data;
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
        last_exp = e;
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    // inputs change with no access: output must hold
    task automatic no_access(input string tag);
        @(negedge clk);
        array_data = array_data + 8'h35;
        last_data  = ~last_data;
        rd_addr    = rd_addr + 1'b1;
        busy       = ~busy;
        exp_q.push_back(last_exp);
        tag_q.push_back(tag);
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; busy = 1'b0; rd_en = 1'b0; rd_addr = '0;
        last_addr = '0; last_data = 8'h00; array_data = 8'h00;
        repeat (3) @(negedge clk);
        chk("R1 reset value", rd_data, 8'h00);
        rst = 1'b0;

        set_ctx(1'b0, 15'h0100, 8'h3C, 8'hA5);
        rd(15'h0040, 1, "R2 idle read");
        set_ctx(1'b0, 15'h0100, 8'h3C, 8'h5A);
        rd(15'h0041, 1, "R2 idle read 2");

        // first write cycle
        set_ctx(1'b1, 15'h0123, 8'h3C, 8'hFF);
        rd(15'h0123, 1, "R1 R3 first busy read bit6=1");
        rd(15'h0123, 1, "R3 R5 second busy read");
        set_ctx(1'b1, 15'h0123, 8'hC3, 8'h00);
        rd(15'h0123, 1, "R3 R5 poll inverted high bit");
        set_ctx(1'b1, 15'h0123, 8'hC3, 8'h81);
        rd(15'h7FFF, 1, "R4 R5 busy other address");
        rd(15'h0000, 1, "R4 R5 busy address changed");
        no_access("R8 hold with inputs changing");
        set_ctx(1'b1, 15'h0123, 8'h3C, 8'h22);
        rd(15'h0123, 4, "R6 held read-enable counts once");
        rd(15'h0123, 1, "R6 R5 next access after hold");

        // write cycle ends
        set_ctx(1'b0, 15'h0123, 8'h3C, 8'h77);
        rd(15'h0123, 1, "R2 first read after busy");
        set_ctx(1'b0, 15'h0123, 8'h3C, 8'hE9);
        rd(15'h0123, 1, "R7 idle read");
        rd(15'h0124, 1, "R7 idle read 2");
        no_access("R8 hold idle");

        // second write cycle continues alternation
        set_ctx(1'b1, 15'h0200, 8'h55, 8'h10);
        rd(15'h0200, 1, "R7 R3 second window first read");
        rd(15'h0200, 1, "R7 R5 second window next read");
        set_ctx(1'b0, 15'h0200, 8'h55, 8'h99);
        rd(15'h0200, 1, "R2 final true data");

        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        vectors++;
        miscomp++;
        $display("FAIL watchdog: run=expired expected=complete");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
        $finish;
    end

endmodule